// File: doc/BRIEF.md
# Prescaled Timer Counter with Compare Reset

This block is the free-running time base of a timer unit. A 16-bit up-counter advances on ticks from a power-of-two prescaler, which divides the clock by 1 to 128 according to a 3-bit select code. Counting is gated by a global enable. A modulus mode can be switched on: when the counter equals the compare value of the designated channel on a tick, the counter returns to zero. When the mode is off, the counter runs freely and sets a sticky overflow flag each time it wraps from 0xFFFF to zero.

Software controls the block through one 8-bit control register. The register holds an interrupt enable, a modulus enable and the prescale code, and it can be read or written at any time. The overflow flag is cleared by writing a one to it. The flag, gated by the interrupt enable, forms the interrupt request. A one-cycle match pulse marks every tick on which the counter equals the compare value.

Top module: `ptc_top`

## Requirements
- R1: After reset the counter, the control register readback, the overflow flag, the interrupt request and the internal prescaler all read zero.
- R2: Prescale code k (0 to 7) divides by 2^k. A 7-bit prescaler advances on each enabled cycle, and a tick occurs when its low k bits are all zero, so code 0 ticks on every enabled cycle. The counter adds one per tick.
- R3: A newly written prescale code is read back at once. It only governs ticks after a clock edge at which the prescaler value is zero.
- R4: With the modulus enable (control bit 3) at 0, the counter wraps from 0xFFFF to 0x0000 and sets the overflow flag on that tick.
- R5: With the modulus enable at 1, a tick on which the counter equals the compare value loads 0x0000 instead of incrementing.
- R6: With the modulus enable at 1 and a compare value of 0x0000, the counter stays at 0x0000.
- R7: With the modulus enable at 1 and a compare value of 0xFFFF, the step from 0xFFFF to 0x0000 does not set the overflow flag.
- R8: A clear write with a data bit of 1 clears the overflow flag. A set event in the same cycle wins over the clear.
- R9: The interrupt request equals the overflow flag ANDed with the interrupt enable (control bit 7).
- R10: While the timer enable is low, the counter and the prescaler hold their values.
- R11: The match pulse is high in exactly the cycles where a tick occurs and the counter equals the compare value, whatever the modulus enable.
- R12: The control register keeps the interrupt enable in bit 7, the modulus enable in bit 3 and the prescale code in bits 2:0. Bits 6:4 read as zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Global timer enable |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ovf_clr_wr | input | 1 | Overflow flag write strobe |
| ovf_clr_data | input | 1 | Overflow flag write data (1 clears) |
| cmp_val | input | 16 | Compare value of the designated channel |
| ctl_rdata | output | 8 | Control register readback |
| cnt_val | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| cmp_hit | output | 1 | Compare-match pulse |

## Verification
Two functions can fall in the same cycle: an overflow set on the 0xFFFF wrap and a software clear of the flag. The bench runs the counter freely up to 0xFFFF and issues the clear write on exactly the wrapping tick. The flag must then read 1, and a later clear alone must drop it. A second collision is a compare reset that lands on the wrap itself, with the compare value at 0xFFFF. Here the counter must return to zero with the flag left at 0. A behavioural model checks every cycle around both events.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int PTC_CNT_W    = 16;
  localparam int PTC_SEL_W    = 3;
  localparam int PTC_CTL_W    = 8;
  localparam int PTC_TOI_BIT  = 7;
  localparam int PTC_TCRE_BIT = 3;

  typedef struct packed {
    logic                 irq_en;
    logic                 mod_en;
    logic [PTC_SEL_W-1:0] psel;
  } ptc_ctl_t;
endpackage

// File: rtl/ptc_ctrl_reg.sv
module ptc_ctrl_reg
  import ptc_pkg::*;
#(
  parameter int CTL_W = PTC_CTL_W,
  parameter int SEL_W = PTC_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output ptc_ctl_t         ctl,
  output logic [CTL_W-1:0] rdata
);
  ptc_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d.irq_en = wdata[PTC_TOI_BIT];
      ctl_d.mod_en = wdata[PTC_TCRE_BIT];
      ctl_d.psel   = wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (wr) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata               = '0;
    rdata[PTC_TOI_BIT]  = ctl_q.irq_en;
    rdata[PTC_TCRE_BIT] = ctl_q.mod_en;
    rdata[SEL_W-1:0]    = ctl_q.psel;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/ptc_prescaler.sv
module ptc_prescaler
  import ptc_pkg::*;
#(
  parameter int SEL_W = PTC_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_req,
  output logic             tick
);
  localparam int NCODE = 1 << SEL_W;
  localparam int PRE_W = NCODE - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEL_W-1:0] act_q;
  logic             pre_zero;
  logic [NCODE-1:0] low_zero;

  assign pre_zero = (pre_q == '0);

  genvar g;
  generate
    for (g = 0; g < NCODE; g++) begin : g_code
      if (g == 0) begin : g_div1
        assign low_zero[g] = 1'b1;
      end else begin : g_divn
        assign low_zero[g] = ~|pre_q[g-1:0];
      end
    end
  endgenerate

  always_comb begin
    pre_d = pre_q + 1'b1;
    tick  = run & low_zero[act_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (run)      pre_q <= pre_d;
      if (pre_zero) act_q <= sel_req;
    end
  end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter
  import ptc_pkg::*;
#(
  parameter int CNT_W = PTC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mod_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             hit,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             at_top, ovf_set;

  always_comb begin
    at_top  = &cnt_q;
    hit     = tick && (cnt_q == cmp_val);
    ovf_set = tick && at_top && !(hit && mod_en);
    cnt_d   = (hit && mod_en) ? '0 : cnt_q + 1'b1;
    if (ovf_set)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/ptc_top.sv
module ptc_top
  import ptc_pkg::*;
#(
  parameter int CNT_W = PTC_CNT_W,
  parameter int SEL_W = PTC_SEL_W,
  parameter int CTL_W = PTC_CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ovf_clr_wr,
  input  logic             ovf_clr_data,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [CNT_W-1:0] cnt_val,
  output logic             ovf_flag,
  output logic             irq,
  output logic             cmp_hit
);
  ptc_ctl_t ctl;
  logic     tick;
  logic     flag_clr;

  assign flag_clr = ovf_clr_wr & ovf_clr_data;

  ptc_ctrl_reg #(.CTL_W(CTL_W), .SEL_W(SEL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl   (ctl),
    .rdata (ctl_rdata)
  );

  ptc_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_en),
    .sel_req (ctl.psel),
    .tick    (tick)
  );

  ptc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mod_en   (ctl.mod_en),
    .cmp_val  (cmp_val),
    .flag_clr (flag_clr),
    .cnt      (cnt_val),
    .hit      (cmp_hit),
    .flag     (ovf_flag)
  );

  assign irq = ovf_flag & ctl.irq_en;
endmodule

// File: rtl/ptc_chk.sv
module ptc_chk
  import ptc_pkg::*;
#(
  parameter int CNT_W = PTC_CNT_W,
  parameter int CTL_W = PTC_CTL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_en,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic [CNT_W-1:0] cnt_val,
  input logic             ovf_flag,
  input logic             irq,
  input logic             cmp_hit
);
  localparam logic [CNT_W-1:0] TOP = '1;

  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt_val) == TOP && cnt_val == '0));

  a_r5_cmp_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && ctl_rdata[PTC_TCRE_BIT]) |=> (cnt_val == '0));

  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[PTC_TCRE_BIT] && cmp_val == '0 && cnt_val == '0) |=> (cnt_val == '0));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> !$past(ctl_rdata[PTC_TCRE_BIT] && cmp_val == TOP));

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && ctl_rdata[PTC_TOI_BIT]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(cnt_val));

  a_r11_hit_cond: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |-> (tmr_en && cnt_val == cmp_val));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_val) |-> (cnt_val == $past(cnt_val) + 1'b1 || cnt_val == '0));

  a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6:4] == 3'b000);
endmodule

bind ptc_top ptc_chk #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tmr_en    (tmr_en),
  .cmp_val   (cmp_val),
  .ctl_rdata (ctl_rdata),
  .cnt_val   (cnt_val),
  .ovf_flag  (ovf_flag),
  .irq       (irq),
  .cmp_hit   (cmp_hit)
);

// File: tb/sim_ptc_top.sv
`timescale 1ns/1ps
module sim_ptc_top;
  logic        clk;
  logic        rst_n;
  logic        tmr_en;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata;
  logic        ovf_clr_wr;
  logic        ovf_clr_data;
  logic [15:0] cmp_val;
  logic [7:0]  ctl_rdata;
  logic [15:0] cnt_val;
  logic        ovf_flag;
  logic        irq;
  logic        cmp_hit;

  ptc_top u0 (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ovf_clr_wr(ovf_clr_wr), .ovf_clr_data(ovf_clr_data),
    .cmp_val(cmp_val), .ctl_rdata(ctl_rdata), .cnt_val(cnt_val),
    .ovf_flag(ovf_flag), .irq(irq), .cmp_hit(cmp_hit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int hits = 0;
  int max_cnt = 0;
  string cur_req = "R1";

  int m_pre, m_act, m_sel, m_toi, m_tcre, m_cnt, m_flag;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int  mask, rd, nxt_cnt, nxt_flag;
    bit  tick, hit, ovs;
    #1;
    mask = (1 << m_act) - 1;
    tick = tmr_en && ((m_pre & mask) == 0);
    hit  = tick && (m_cnt == int'(cmp_val));
    ovs  = tick && (m_cnt == 65535) && !(m_tcre != 0 && hit);
    rd   = (m_toi << 7) | (m_tcre << 3) | m_sel;
    check(int'(cnt_val) == m_cnt, cur_req, "cnt_val", cnt_val, m_cnt);
    check(int'(ovf_flag) == m_flag, cur_req, "ovf_flag", ovf_flag, m_flag);
    check(int'(irq) == (m_flag & m_toi), "R9", "irq", irq, m_flag & m_toi);
    check(cmp_hit == hit, "R11", "cmp_hit", cmp_hit, hit);
    check(int'(ctl_rdata) == rd, "R12", "ctl_rdata", ctl_rdata, rd);
    if (cmp_hit) hits++;
    if (int'(cnt_val) > max_cnt) max_cnt = int'(cnt_val);
    nxt_cnt  = tick ? ((hit && m_tcre != 0) ? 0 : (m_cnt + 1) % 65536) : m_cnt;
    nxt_flag = ovs ? 1 : ((ovf_clr_wr && ovf_clr_data) ? 0 : m_flag);
    if (m_pre == 0) m_act = m_sel;
    if (tmr_en) m_pre = (m_pre + 1) % 128;
    m_cnt  = nxt_cnt;
    m_flag = nxt_flag;
    if (ctl_wr) begin
      m_toi  = int'(ctl_wdata[7]);
      m_tcre = int'(ctl_wdata[3]);
      m_sel  = int'(ctl_wdata[2:0]);
    end
    @(negedge clk);
    ctl_wr     = 1'b0;
    ovf_clr_wr = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr    = 1'b1;
    ctl_wdata = v;
    step();
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      finish_up();
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; tmr_en = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00;
    ovf_clr_wr = 1'b0; ovf_clr_data = 1'b0; cmp_val = 16'hFFFF;
    m_pre = 0; m_act = 0; m_sel = 0; m_toi = 0; m_tcre = 0; m_cnt = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(cnt_val == 16'h0 && ctl_rdata == 8'h0 && !ovf_flag && !irq, "R1",
          "reset state", {cnt_val, ctl_rdata}, 0);

    // R2 and R4: free run at divide-by-1 up to the wrap
    cur_req = "R2";
    tmr_en = 1'b1;
    run(20);
    check(int'(cnt_val) == 20, "R2", "divide-by-1 count", cnt_val, 20);
    cur_req = "R4";
    while (m_cnt != 65535) step();
    // R8: clear write on the wrapping tick, set must win
    ovf_clr_wr = 1'b1; ovf_clr_data = 1'b1;
    step();
    check(ovf_flag == 1'b1, "R8", "set beats clear", ovf_flag, 1);
    check(ovf_flag == 1'b1 && cnt_val == 16'h0, "R4", "wrap flag", ovf_flag, 1);
    // R9: enable the interrupt
    wr_ctl(8'h80);
    check(irq == 1'b1, "R9", "irq asserted", irq, 1);
    ovf_clr_wr = 1'b1; ovf_clr_data = 1'b0;
    step();
    check(ovf_flag == 1'b1, "R8", "zero write keeps flag", ovf_flag, 1);
    ovf_clr_wr = 1'b1; ovf_clr_data = 1'b1;
    step();
    check(ovf_flag == 1'b0 && irq == 1'b0, "R8", "flag cleared", ovf_flag, 0);

    // R10: hold while disabled
    cur_req = "R10";
    c0 = int'(cnt_val);
    tmr_en = 1'b0;
    run(10);
    check(int'(cnt_val) == c0, "R10", "hold while disabled", cnt_val, c0);

    // R5 and R11: modulus count to 20
    cur_req = "R5";
    tmr_en = 1'b1;
    cmp_val = 16'd20;
    wr_ctl(8'h08);
    hits = 0; max_cnt = 0;
    run(100);
    check(max_cnt <= 20, "R5", "modulus bound", max_cnt, 20);
    check(hits >= 4, "R11", "match pulses", hits, 4);

    // R6: compare zero pins the counter
    cur_req = "R6";
    for (int i = 0; i < 40 && m_cnt != 0; i++) step();
    cmp_val = 16'd0;
    run(50);
    check(cnt_val == 16'h0, "R6", "stuck at zero", cnt_val, 0);

    // R2 and R3: prescale changes with deferred effect
    cur_req = "R3";
    cmp_val = 16'hFFFF;
    wr_ctl(8'h03);
    check(ctl_rdata[2:0] == 3'd3, "R3", "code read back at once", ctl_rdata[2:0], 3);
    run(300);
    wr_ctl(8'h05);
    run(300);
    cur_req = "R2";
    wr_ctl(8'h07);
    run(400);
    c0 = int'(cnt_val);
    run(128);
    check(int'(cnt_val) == c0 + 1, "R2", "divide-by-128 step", cnt_val, c0 + 1);
    cur_req = "R10";
    tmr_en = 1'b0;
    run(7);
    tmr_en = 1'b1;
    cur_req = "R3";
    wr_ctl(8'h01);
    run(300);

    // R7: compare at 0xFFFF, wrap is a compare reset
    cur_req = "R7";
    wr_ctl(8'h08);
    run(140);
    for (int i = 0; i < 70000 && m_cnt != 65535; i++) step();
    hits = 0;
    step();
    check(cnt_val == 16'h0 && ovf_flag == 1'b0, "R7", "no flag on compare wrap",
          ovf_flag, 0);
    check(hits == 1, "R11", "match at top", hits, 1);

    // R12: reserved bits read zero
    wr_ctl(8'hF5);
    #1;
    check(ctl_rdata == 8'h85, "R12", "readback layout", ctl_rdata, 8'h85);
    run(5);
    finish_up();
  end
endmodule